// File: doc/BRIEF.md
# Divided-Clock LFSR Test Pattern Generator

This block produces pseudorandom test patterns for built-in self-test. Its core is a standard external-feedback shift register of the kind used to compact responses. Its serial input does not take a circuit response. It takes a slow square wave generated inside the block, with a period of `ratio` register cycles. Feeding that wave in stretches the pattern sequence past the usual maximal length. It also lets the register pass through the all-zero state and leave it again without help.

Everything runs in one clock domain. A counter derives the slow wave from the register clock. The wave is high for the first ceil(r/2) enabled cycles of each r-cycle period and low for the rest. Loading a seed starts the wave at the beginning of its high half. An override input replaces the wave with an external serial bit, which turns the block back into an ordinary signature register. With the default configuration the register has three stages, polynomial x^3 + x^2 + 1, and reset seed 100 (written MSB first as Q2 Q1 Q0).

Top module: `lfsr_divclk_tpg`

## Requirements
- R1: After synchronous reset, `pattern` reads 100 and the wave phase is at its start.
- R2: On each enabled cycle without load, the register shifts one place toward bit 0. The new bit 2 is bit 2 XOR bit 0 XOR the injected bit. With the injected bit held at 0 and starting from 100, the order is 100, 110, 111, 011, 101, 010, 001, and then it repeats.
- R3: When `load` is high, `pattern` equals `seed` on the next cycle, whatever the value of `en`. The wave phase restarts at the same time.
- R4: While `en` is low and `load` is low, `pattern` and the wave phase both hold.
- R5: For `ratio` of 2 or more, the injected bit is 1 for the first ceil(ratio/2) enabled cycles after a load and 0 for the remaining cycles of each `ratio`-cycle period, repeating. For `ratio` of 0 or 1 the injected bit is 0.
- R6: From seed 100, the joint period (pattern and wave phase) is 7 for ratio 0 or 1, 14 for ratio 2, and 7×ratio for ratios 3 to 6.
- R7: From seed 100, the period is 14 for ratio 7, 14 for ratio 14, 42 for ratio 21, and 28 for ratio 28.
- R8: With ratio 2 and seed 100, the register reaches 000 after 3 steps, stays there for one more step, and shows 100 after the fifth step.
- R9: With ratio 2 and seed 010, the register is trapped: it alternates 101, 010 and never leaves these two states.
- R10: While `ovr_en` is high, the injected bit is `ovr_bit` and the wave has no effect. With `ovr_bit` at 0 the R2 order holds for any ratio, and from 000 with `ovr_bit` at 1 the next pattern is 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load `seed` and restart the wave phase |
| seed | input | WIDTH | Value loaded into the register |
| en | input | 1 | Advance the register and the wave by one step |
| ratio | input | RATIO_W | Wave period in register cycles |
| ovr_en | input | 1 | Select `ovr_bit` as the injected serial bit |
| ovr_bit | input | 1 | External serial bit used when `ovr_en` is high |
| pattern | output | WIDTH | Current register contents (the test pattern) |

## Verification
A corrupted register bit shows at `pattern` on the very next enabled step, because every state bit either is shifted out or feeds the new top bit. A wrong wave phase stays hidden until the first cycle where the wrong level is injected. For large ratios that can be up to ceil(r/2) steps later, so the bench follows every step of whole periods against its own model rather than sampling only the endpoints. The period measurements catch small duty-cycle or wrap errors that per-step checks over a short window would miss, because such errors change the sequence length.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Where the serial bit fed into the register comes from.
  typedef enum logic {
    INJ_WAVE = 1'b0,
    INJ_EXT  = 1'b1
  } inj_src_e;

  // Number of high cycles in one wave period: ceil(r/2).
  function automatic int unsigned high_span(input int unsigned r);
    return (r + 1) / 2;
  endfunction

  // A wave exists only for periods of two cycles or more.
  function automatic logic wave_active(input int unsigned r);
    return r >= 2;
  endfunction

endpackage

// File: rtl/tpg_wave_gen.sv
module tpg_wave_gen #(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               advance,
  input  logic [RATIO_W-1:0] ratio,
  output logic               level,
  output logic               wrap
);
  import tpg_pkg::*;

  logic [RATIO_W-1:0] phase_q;
  logic               active;
  logic               at_end;

  assign active = wave_active(32'(ratio));
  assign at_end = active && (phase_q >= (ratio - RATIO_W'(1)));
  assign wrap   = advance && at_end;
  assign level  = active && (32'(phase_q) < high_span(32'(ratio)));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (advance) begin
      if (!active || at_end) phase_q <= '0;
      else                   phase_q <= phase_q + RATIO_W'(1);
    end
  end

endmodule

// File: rtl/tpg_lfsr_core.sv
module tpg_lfsr_core #(
  parameter int unsigned       WIDTH      = 3,
  parameter logic [WIDTH-1:0]  TAP_MASK   = 3'b101,
  parameter logic [WIDTH-1:0]  RESET_SEED = 3'b100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             step,
  input  logic             din,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;
  logic             feedback;

  assign feedback = (^(state_q & TAP_MASK)) ^ din;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH - 1; gi++) begin : g_shift
      assign state_nxt[gi] = state_q[gi+1];
    end
  endgenerate
  assign state_nxt[WIDTH-1] = feedback;

  always_ff @(posedge clk) begin
    if (rst)       state_q <= RESET_SEED;
    else if (load) state_q <= seed;
    else if (step) state_q <= state_nxt;
  end

  assign state = state_q;

endmodule

// File: rtl/lfsr_divclk_tpg.sv
module lfsr_divclk_tpg #(
  parameter int unsigned      WIDTH      = 3,
  parameter logic [WIDTH-1:0] TAP_MASK   = 3'b101,
  parameter logic [WIDTH-1:0] RESET_SEED = 3'b100,
  parameter int unsigned      RATIO_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WIDTH-1:0]   seed,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ovr_en,
  input  logic               ovr_bit,
  output logic [WIDTH-1:0]   pattern
);
  import tpg_pkg::*;

  logic     step_ev;
  logic     wave_level;
  logic     wave_wrap;
  logic     inj_bit;
  inj_src_e inj_src;

  assign step_ev = en && !load;
  assign inj_src = ovr_en ? INJ_EXT : INJ_WAVE;

  always_comb begin
    unique case (inj_src)
      INJ_EXT:  inj_bit = ovr_bit;
      default:  inj_bit = wave_level;
    endcase
  end

  tpg_wave_gen #(
    .RATIO_W (RATIO_W)
  ) u_wave (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .advance (step_ev),
    .ratio   (ratio),
    .level   (wave_level),
    .wrap    (wave_wrap)
  );

  tpg_lfsr_core #(
    .WIDTH      (WIDTH),
    .TAP_MASK   (TAP_MASK),
    .RESET_SEED (RESET_SEED)
  ) u_core (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .seed  (seed),
    .step  (step_ev),
    .din   (inj_bit),
    .state (pattern)
  );

endmodule

// File: rtl/lfsr_divclk_tpg_chk.sv
module lfsr_divclk_tpg_chk #(
  parameter int unsigned      WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 3'b101,
  parameter int unsigned      RATIO_W  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               load,
  input logic [WIDTH-1:0]   seed,
  input logic               en,
  input logic [RATIO_W-1:0] ratio,
  input logic               ovr_en,
  input logic               ovr_bit,
  input logic [WIDTH-1:0]   pattern,
  input logic               wave_level,
  input logic               wave_wrap
);

  // R3
  load_seed_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> pattern == $past(seed));

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(pattern));

  // R2
  shift_down_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> pattern[WIDTH-2:0] == $past(pattern[WIDTH-1:1]));

  // R2
  feedback_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !ovr_en) |=>
      pattern[WIDTH-1] == ($past(^(pattern & TAP_MASK)) ^ $past(wave_level)));

  // R5
  wave_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio < RATIO_W'(2)) |-> !wave_level && !wave_wrap);

  // R5
  wave_start_chk: assert property (@(posedge clk) disable iff (rst)
    load ##1 (ratio >= RATIO_W'(2)) |-> wave_level);

  // R10
  override_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && ovr_en) |=>
      pattern[WIDTH-1] == ($past(^(pattern & TAP_MASK)) ^ $past(ovr_bit)));

endmodule

bind lfsr_divclk_tpg lfsr_divclk_tpg_chk #(
  .WIDTH    (WIDTH),
  .TAP_MASK (TAP_MASK),
  .RATIO_W  (RATIO_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .seed       (seed),
  .en         (en),
  .ratio      (ratio),
  .ovr_en     (ovr_en),
  .ovr_bit    (ovr_bit),
  .pattern    (pattern),
  .wave_level (wave_level),
  .wave_wrap  (wave_wrap)
);

// File: tb/lfsr_divclk_tpg_bench.sv
module lfsr_divclk_tpg_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [2:0] seed = 3'b000;
  logic       en = 1'b0;
  logic [5:0] ratio = 6'd0;
  logic       ovr_en = 1'b0;
  logic       ovr_bit = 1'b0;
  logic [2:0] pattern;

  int checks = 0;
  int failures = 0;

  // bench model of the generator
  logic [2:0] m_state;
  int         m_phase;

  always #2 clk = ~clk;

  lfsr_divclk_tpg u_lfsr_divclk_tpg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .seed    (seed),
    .en      (en),
    .ratio   (ratio),
    .ovr_en  (ovr_en),
    .ovr_bit (ovr_bit),
    .pattern (pattern)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Injected bit per R5 / R10, computed from the bench's own phase count.
  function automatic bit model_inj();
    int r;
    r = int'(ratio);
    if (ovr_en) return ovr_bit;
    if (r < 2) return 1'b0;
    return m_phase < (r + 1) / 2;
  endfunction

  task automatic model_step();
    bit d;
    int r;
    r = int'(ratio);
    d = model_inj();
    m_state = {m_state[2] ^ m_state[0] ^ d, m_state[2], m_state[1]};
    if (r >= 2) m_phase = (m_phase + 1 == r) ? 0 : m_phase + 1;
    else        m_phase = 0;
  endtask

  task automatic do_load(input logic [2:0] s, input string req);
    seed = s;
    load = 1'b1;
    tick();
    load = 1'b0;
    m_state = s;
    m_phase = 0;
    chk(pattern == s, req, pattern, s);
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    chk(pattern == 3'b100, "R1 reset pattern", pattern, 3'b100);
    tick();
    chk(pattern == 3'b100, "R1 idle after reset", pattern, 3'b100);
  endtask

  // R2: conventional order with ratio 0
  task automatic t_conventional();
    logic [2:0] order [7];
    order = '{3'b110, 3'b111, 3'b011, 3'b101, 3'b010, 3'b001, 3'b100};
    ratio = 6'd0;
    ovr_en = 1'b0;
    en = 1'b1;
    do_load(3'b100, "R3 load with enable high");
    for (int i = 0; i < 7; i++) begin
      tick();
      chk(pattern == order[i], "R2 conventional order", pattern, order[i]);
    end
  endtask

  // R6 / R7 (R5 exercised at every step through the model)
  task automatic t_period(input int r, input int exp_len, input string req);
    int n;
    bit found;
    bit step_ok;
    ratio = 6'(r);
    ovr_en = 1'b0;
    en = 1'b1;
    do_load(3'b100, "R3 load before period run");
    n = 0;
    found = 1'b0;
    step_ok = 1'b1;
    for (int i = 1; i <= 400 && !found; i++) begin
      model_step();
      tick();
      if (pattern != m_state && step_ok) begin
        step_ok = 1'b0;
        chk(1'b0, "R5 step against model", pattern, m_state);
      end
      if (pattern == 3'b100 && (r < 2 || (i % r) == 0)) begin
        found = 1'b1;
        n = i;
      end
    end
    if (step_ok) chk(1'b1, "R5 step against model", 0, 0);
    chk(n == exp_len, req, n, exp_len);
  endtask

  // R4: hold with enable low, then continue in step with the model
  task automatic t_hold();
    logic [2:0] snap;
    ratio = 6'd4;
    ovr_en = 1'b0;
    en = 1'b1;
    do_load(3'b100, "R3 load before hold");
    for (int i = 0; i < 3; i++) begin
      model_step();
      tick();
    end
    snap = pattern;
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(pattern == snap, "R4 hold with enable low", pattern, snap);
    end
    en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      model_step();
      tick();
      chk(pattern == m_state, "R4 wave phase held across pause", pattern, m_state);
    end
    en = 1'b0;
    do_load(3'b011, "R3 load with enable low");
  endtask

  // R8: pass through all-zero and out again
  task automatic t_zero();
    ratio = 6'd2;
    ovr_en = 1'b0;
    en = 1'b1;
    do_load(3'b100, "R3 load before zero test");
    repeat (3) tick();
    chk(pattern == 3'b000, "R8 reaches zero", pattern, 3'b000);
    tick();
    chk(pattern == 3'b000, "R8 stays zero one step", pattern, 3'b000);
    tick();
    chk(pattern == 3'b100, "R8 leaves zero", pattern, 3'b100);
  endtask

  // R9: trapped pair
  task automatic t_trap();
    ratio = 6'd2;
    ovr_en = 1'b0;
    en = 1'b1;
    do_load(3'b010, "R3 load trap seed");
    for (int i = 0; i < 8; i++) begin
      logic [2:0] want;
      want = (i % 2 == 0) ? 3'b101 : 3'b010;
      tick();
      chk(pattern == want, "R9 trapped alternation", pattern, want);
    end
  endtask

  // R10: external bit replaces the wave
  task automatic t_override();
    logic [2:0] order [7];
    order = '{3'b110, 3'b111, 3'b011, 3'b101, 3'b010, 3'b001, 3'b100};
    ratio = 6'd2;
    ovr_en = 1'b1;
    ovr_bit = 1'b0;
    en = 1'b1;
    do_load(3'b100, "R3 load before override");
    for (int i = 0; i < 7; i++) begin
      tick();
      chk(pattern == order[i], "R10 override zero ignores wave", pattern, order[i]);
    end
    do_load(3'b000, "R3 load zero seed");
    ovr_bit = 1'b1;
    tick();
    chk(pattern == 3'b100, "R10 override one from zero", pattern, 3'b100);
    ovr_en = 1'b0;
    ovr_bit = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_conventional();
    t_period(0,  7,  "R6 period ratio 0");
    t_period(1,  7,  "R6 period ratio 1");
    t_period(2,  14, "R6 period ratio 2");
    t_period(3,  21, "R6 period ratio 3");
    t_period(4,  28, "R6 period ratio 4");
    t_period(5,  35, "R6 period ratio 5");
    t_period(6,  42, "R6 period ratio 6");
    t_period(7,  14, "R7 period ratio 7");
    t_period(14, 14, "R7 period ratio 14");
    t_period(21, 42, "R7 period ratio 21");
    t_period(28, 28, "R7 period ratio 28");
    t_hold();
    t_zero();
    t_trap();
    t_override();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule